// File: doc/BRIEF.md
# PHY Management Bus Master with Command Word

This block is a management-bus controller that gives a host access to the registers of an external Ethernet PHY through a single 32-bit command word. The host writes the word with the start flag set. The word names the PHY address, the register address, the direction and, for a write, 16 data bits. The block serialises a standard clause-22 management frame on the MDC clock and MDIO data line. It checks the acknowledge in the turnaround slot. It then clears the start flag and reports the acknowledge, plus read data, in the same word. The host polls the word until the start flag drops.

The PHY may come up at any of 32 addresses, so software cannot assume where it lives. For that reason the block also runs a background scan. Whenever the bus has been idle for a programmable gap, it reads the basic status register of the next address in turn. From these reads it keeps two 32-bit maps: one marks the addresses that answered, and one marks the addresses that answered and report link up. Host commands take precedence over the scan. Neither kind of frame ever interrupts a frame already on the bus.

Top module: `mdio_user_master`

## Requirements
- R1: The command word holds the start flag in bit 31, the write flag in bit 30 (0 read, 1 write), the acknowledge in bit 29, the register address in bits 25:21, the PHY address in bits 20:16 and data in bits 15:0; bits 28:26 always read 0. Writing the word with bit 31 set starts a transaction.
- R2: While a transaction is pending or on the bus, bit 31 reads 1 and the rest of the word reads back the command as written. When the frame completes, bit 31 clears.
- R3: A host write to the word while bit 31 is 1 is ignored: it changes no field and launches no frame.
- R4: Each frame is 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, a 2-bit turnaround (10 driven by the master on writes) and 16 data bits, with every field sent MSB first.
- R5: MDC runs at the system clock divided by 2*DIV_HALF (DIV_HALF >= 2). The master changes MDIO only in the cycle in which MDC falls and samples it at the rising edge.
- R6: On a read, the master releases MDIO from the first turnaround bit to the end of the frame. The acknowledge bit is set only if the PHY holds the second turnaround bit low. With the acknowledge set, bits 15:0 hold the 16 bits returned; without it, bits 15:0 keep the value written.
- R7: A completed write sets the acknowledge bit, leaves bits 15:0 as written, and updates the addressed PHY register.
- R8: After every POLL_GAP idle cycles, the scanner reads register STAT_REG (default 1) of the next address, going 0 to 31 cyclically. The alive bit of that address is set to the acknowledge, and its link bit to the acknowledge AND bit LINK_BIT (default 2) of the data read. A link bit is never set without its alive bit.
- R9: A pending host command is issued ahead of a pending scan read. It completes within two frame times after it is written.
- R10: After reset the command word and both maps are 0 and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Host write strobe for the command word |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Command word read-back |
| alive_o | output | 32 | Per-address map of PHYs that acknowledged a scan read |
| link_o | output | 32 | Per-address map of PHYs reporting link up |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bound assertions check the cycle-level rules on every cycle. The start flag holds until its own frame ends, and then clears. The word stays frozen under host writes while the flag is set. MDIO changes only at an MDC falling edge, and MDC keeps its minimum high time. The reserved bits stay zero, and no link bit is set without its alive bit. Other behaviour needs the PHY stub and the bench scenarios. These are the frame encoding, the turnaround acknowledge, the read data returned, the writes that land in the stub, the absent-address case, host priority over the scan, and the two maps after full scan rounds with the link first up and then down.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int GO_BIT    = 31;
  localparam int WR_BIT    = 30;
  localparam int ACK_BIT   = 29;
  localparam int REG_LSB   = 21;
  localparam int PHY_LSB   = 16;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int NUM_ADDR  = 1 << ADDR_W;
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int ACK_IDX   = 47;
  localparam int DATA_IDX  = 48;
  localparam int LAST_IDX  = FRAME_LEN - 1;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;

  typedef enum logic {OWN_USER = 1'b0, OWN_POLL = 1'b1} owner_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          term;

  assign term = (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // strobes mark the clock edge at which mdc toggles
  assign rise_o = term & ~mdc_q;
  assign fall_o = term &  mdc_q;
  assign mdc_o  = mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IW = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] frame_q;
  logic [IW-1:0]        idx_q;
  logic                 busy_q, primed_q, rd_q, ack_q, done_q, mdio_q, oe_q;
  logic [DATA_W-1:0]    shift_q;
  logic [1:0]           opcode;

  assign opcode = cmd_i.wr ? 2'b01 : 2'b10;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= '0;
      idx_q    <= '0;
      busy_q   <= 1'b0;
      primed_q <= 1'b0;
      rd_q     <= 1'b0;
      ack_q    <= 1'b0;
      done_q   <= 1'b0;
      mdio_q   <= 1'b1;
      oe_q     <= 1'b0;
      shift_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        frame_q  <= {32'hFFFF_FFFF, 2'b01, opcode, cmd_i.phy, cmd_i.regad, 2'b10,
                     cmd_i.wr ? cmd_i.data : {DATA_W{1'b1}}};
        rd_q     <= ~cmd_i.wr;
        busy_q   <= 1'b1;
        primed_q <= 1'b0;
        idx_q    <= '0;
        ack_q    <= 1'b0;
      end else if (busy_q) begin
        if (fall_i) begin
          primed_q <= 1'b1;
          mdio_q   <= frame_q[FRAME_LEN-1];
          oe_q     <= !(rd_q && (idx_q >= IW'(TA_IDX)));
        end else if (rise_i && primed_q) begin
          frame_q <= frame_q << 1;
          if (idx_q == IW'(ACK_IDX))
            ack_q <= rd_q ? ~mdio_i : 1'b1;
          if (idx_q >= IW'(DATA_IDX))
            shift_q <= {shift_q[DATA_W-2:0], mdio_i};
          if (idx_q == IW'(LAST_IDX)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end else if (fall_i) begin
        // release only at a falling edge so the last bit holds through its rising edge
        oe_q   <= 1'b0;
        mdio_q <= 1'b1;
      end
    end
  end

  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign ack_o     = ack_q;
  assign rdata_o   = shift_q;
endmodule

// File: rtl/mdio_poller.sv
module mdio_poller
  import mdio_pkg::*;
#(
  parameter int POLL_GAP = 256,
  parameter int LINK_BIT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                grant_i,
  input  logic                done_i,
  input  logic                ack_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic                req_o,
  output logic [ADDR_W-1:0]   phy_o,
  output logic [NUM_ADDR-1:0] alive_o,
  output logic [NUM_ADDR-1:0] link_o
);
  localparam int GW = $clog2(POLL_GAP + 1);

  logic [GW-1:0]       gap_q;
  logic                wait_q;
  logic [ADDR_W-1:0]   idx_q;
  logic [NUM_ADDR-1:0] alive_q, link_q;
  logic                gap_full;

  assign gap_full = (gap_q == GW'(POLL_GAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      wait_q  <= 1'b0;
      idx_q   <= '0;
      alive_q <= '0;
      link_q  <= '0;
    end else if (grant_i) begin
      wait_q <= 1'b1;
      gap_q  <= '0;
    end else if (wait_q && done_i) begin
      wait_q         <= 1'b0;
      alive_q[idx_q] <= ack_i;
      link_q[idx_q]  <= ack_i & rdata_i[LINK_BIT];
      idx_q          <= idx_q + 1'b1;
    end else if (!wait_q && !gap_full) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign req_o   = gap_full && !wait_q;
  assign phy_o   = idx_q;
  assign alive_o = alive_q;
  assign link_o  = link_q;
endmodule

// File: rtl/mdio_user_master.sv
module mdio_user_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int POLL_GAP = 256,
  parameter int STAT_REG = 1,
  parameter int LINK_BIT = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic [31:0] alive_o,
  output logic [31:0] link_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              rise, fall;
  logic              eng_busy, eng_done, eng_ack;
  logic [DATA_W-1:0] eng_rdata;
  logic              poll_req;
  logic [ADDR_W-1:0] poll_phy;
  mdio_cmd_t         cmd;

  logic              go_q, wr_q, ack_q, inflight_q;
  logic [ADDR_W-1:0] regad_q, phy_q;
  logic [DATA_W-1:0] data_q;
  owner_e            owner_q;

  logic user_pend, can_start, start, grant_poll, user_done;

  assign user_pend  = go_q && !inflight_q;
  assign can_start  = !eng_busy && !eng_done;
  assign start      = can_start && (user_pend || poll_req);
  assign grant_poll = start && !user_pend;
  assign user_done  = eng_done && (owner_q == OWN_USER) && inflight_q;

  always_comb begin
    if (user_pend) begin
      cmd.wr    = wr_q;
      cmd.phy   = phy_q;
      cmd.regad = regad_q;
      cmd.data  = data_q;
    end else begin
      cmd.wr    = 1'b0;
      cmd.phy   = poll_phy;
      cmd.regad = ADDR_W'(STAT_REG);
      cmd.data  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q       <= 1'b0;
      wr_q       <= 1'b0;
      ack_q      <= 1'b0;
      regad_q    <= '0;
      phy_q      <= '0;
      data_q     <= '0;
      inflight_q <= 1'b0;
      owner_q    <= OWN_POLL;
    end else begin
      if (reg_wr_i && !go_q) begin
        go_q    <= reg_wdata_i[GO_BIT];
        wr_q    <= reg_wdata_i[WR_BIT];
        ack_q   <= 1'b0;
        regad_q <= reg_wdata_i[REG_LSB +: ADDR_W];
        phy_q   <= reg_wdata_i[PHY_LSB +: ADDR_W];
        data_q  <= reg_wdata_i[DATA_W-1:0];
      end
      if (start) begin
        owner_q <= user_pend ? OWN_USER : OWN_POLL;
        if (user_pend) inflight_q <= 1'b1;
      end
      if (user_done) begin
        go_q       <= 1'b0;
        inflight_q <= 1'b0;
        ack_q      <= eng_ack;
        if (!wr_q && eng_ack) data_q <= eng_rdata;
      end
    end
  end

  assign reg_rdata_o = {go_q, wr_q, ack_q, 3'b000, regad_q, phy_q, data_q};

  mdio_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame_eng u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .fall_i   (fall),
    .start_i  (start),
    .cmd_i    (cmd),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .ack_o    (eng_ack),
    .rdata_o  (eng_rdata)
  );

  mdio_poller #(.POLL_GAP(POLL_GAP), .LINK_BIT(LINK_BIT)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .grant_i(grant_poll),
    .done_i (eng_done && (owner_q == OWN_POLL)),
    .ack_i  (eng_ack),
    .rdata_i(eng_rdata),
    .req_o  (poll_req),
    .phy_o  (poll_phy),
    .alive_o(alive_o),
    .link_o (link_o)
  );
endmodule

// File: rtl/mdio_user_master_chk.sv
module mdio_user_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic [31:0] word_i,
  input logic [31:0] alive_i,
  input logic [31:0] link_i,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        user_done_i
);
  AST_GO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i[31] && !user_done_i) |=> word_i[31]); // R2
  AST_GO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_done_i |=> !word_i[31]); // R2
  AST_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i[31] && reg_wr_i && !user_done_i) |=> $stable(word_i)); // R3
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_i[28:26] == 3'b000); // R1
  AST_MDIO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_i) |-> $fell(mdc_i)); // R5
  AST_MDC_HIGH_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_i) |=> mdc_i); // R5
  AST_LINK_IMPLIES_ALIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_i & ~alive_i) == 32'h0); // R8
endmodule

bind mdio_user_master mdio_user_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .word_i     (reg_rdata_o),
  .alive_i    (alive_o),
  .link_i     (link_o),
  .mdc_i      (mdc_o),
  .mdio_i     (mdio_o),
  .user_done_i(user_done)
);

// File: tb/mdio_user_master_tb.sv
`timescale 1ns/1ps
module mdio_user_master_tb;
  localparam int DIV_HALF = 2;
  localparam int POLL_GAP = 8;
  localparam logic [4:0] PHY_AT = 5'd5;
  localparam logic [4:0] PHY_NONE = 5'd9;
  localparam int FRAME_CYC = 64 * 2 * DIV_HALF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, alive, link;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_oe = 1'b0, phy_d = 1'b1;
  logic        mdio_line;
  int          checks = 0, errors = 0, cyc = 0, max_lat = 0;
  logic [15:0] phy_regs [32];

  assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_d : 1'b1);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_user_master #(.DIV_HALF(DIV_HALF), .POLL_GAP(POLL_GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .alive_o(alive), .link_o(link), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_line)
  );

  function automatic logic [15:0] init_val(int r);
    return (r == 1) ? 16'h796D : (16'hA5C3 ^ (16'(r) * 16'h0101));
  endfunction

  function automatic logic [31:0] mk(logic go, logic wr, logic ack, logic [4:0] ra,
                                     logic [4:0] pa, logic [15:0] d);
    return {go, wr, ack, 3'b000, ra, pa, d};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // PHY stub: answers only at PHY_AT, drives on MDC falling edges
  initial begin
    int st, ones, cnt;
    logic [11:0] hdr;
    logic [17:0] wbuf;
    logic [4:0]  pa, ra;
    st = 0; ones = 0; cnt = 0; hdr = '0; wbuf = '0; pa = '0; ra = '0;
    for (int r = 0; r < 32; r++) phy_regs[r] = init_val(r);
    forever begin
      @(posedge mdc);
      case (st)
        0: if (mdio_line) begin if (ones < 64) ones++; end
           else begin if (ones >= 32) st = 1; ones = 0; end
        1: if (mdio_line) begin st = 2; cnt = 0; hdr = '0; end else st = 0;
        2: begin
          hdr = {hdr[10:0], mdio_line}; cnt++;
          if (cnt == 12) begin
            pa = hdr[9:5]; ra = hdr[4:0];
            if (hdr[11:10] == 2'b10 && pa == PHY_AT) begin
              @(negedge mdc);
              @(negedge mdc); phy_oe = 1'b1; phy_d = 1'b0;
              for (int i = 15; i >= 0; i--) begin @(negedge mdc); phy_d = phy_regs[ra][i]; end
              @(negedge mdc); phy_oe = 1'b0; phy_d = 1'b1;
              st = 0; ones = 0;
            end else if (hdr[11:10] == 2'b01) begin
              st = 3; cnt = 0;
            end else begin
              st = 0; ones = 0;
            end
          end
        end
        3: begin
          wbuf = {wbuf[16:0], mdio_line}; cnt++;
          if (cnt == 18) begin
            if (pa == PHY_AT && wbuf[17:16] == 2'b10) phy_regs[ra] = wbuf[15:0];
            st = 0; ones = 0;
          end
        end
        default: st = 0;
      endcase
    end
  end

  task automatic do_cmd(input logic [31:0] cmd, output logic [31:0] res);
    int lat;
    @(negedge clk); reg_wr = 1'b1; wdata = cmd;
    @(negedge clk); reg_wr = 1'b0;
    lat = 1;
    chk(rdata == cmd, "R2 pending read-back", rdata, cmd);
    while (rdata[31]) begin @(negedge clk); lat++; end
    if (lat > max_lat) max_lat = lat;
    res = rdata;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] res, exp_w;
    logic [15:0] w;
    int t0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rdata == 32'h0, "R10 word after reset", rdata, 32'h0);
    chk(alive == 32'h0 && link == 32'h0, "R10 maps after reset", alive | link, 32'h0);
    chk(mdio_oe == 1'b0, "R10 mdio released", {31'h0, mdio_oe}, 32'h0);

    // R5: MDC period
    @(posedge mdc); t0 = cyc;
    @(posedge mdc);
    chk((cyc - t0) == 2 * DIV_HALF, "R5 mdc period", 32'(cyc - t0), 32'(2 * DIV_HALF));

    // R3: second write while busy is ignored
    @(negedge clk); reg_wr = 1'b1; wdata = mk(1, 0, 0, 5'd0, PHY_AT, 16'h0);
    @(negedge clk); reg_wr = 1'b0;
    repeat (10) @(negedge clk);
    reg_wr = 1'b1; wdata = mk(1, 1, 0, 5'd2, PHY_NONE, 16'hBEEF);
    @(negedge clk); reg_wr = 1'b0;
    exp_w = mk(1, 0, 0, 5'd0, PHY_AT, 16'h0);
    chk(rdata == exp_w, "R3 word unchanged by write while busy", rdata, exp_w);
    while (rdata[31]) @(negedge clk);
    exp_w = mk(0, 0, 1, 5'd0, PHY_AT, init_val(0));
    chk(rdata == exp_w, "R3 result of first command", rdata, exp_w);
    repeat (600) @(negedge clk);
    chk(rdata == exp_w, "R3 no second frame launched", rdata, exp_w);
    chk(phy_regs[2] == init_val(2), "R3 ignored write never reached bus",
        {16'h0, phy_regs[2]}, {16'h0, init_val(2)});

    // R6/R1: read sweep over all registers
    for (int r = 0; r < 32; r++) begin
      do_cmd(mk(1, 0, 0, 5'(r), PHY_AT, 16'h0), res);
      exp_w = mk(0, 0, 1, 5'(r), PHY_AT, phy_regs[r]);
      chk(res == exp_w, "R6 R1 read sweep", res, exp_w);
    end

    // R6: absent address, no acknowledge, data kept
    do_cmd(mk(1, 0, 0, 5'd3, PHY_NONE, 16'h1234), res);
    exp_w = mk(0, 0, 0, 5'd3, PHY_NONE, 16'h1234);
    chk(res == exp_w, "R6 no-ack read", res, exp_w);

    // R7/R4: write sweep with read-back
    for (int r = 0; r < 32; r++) begin
      if (r != 1) begin
        w = ~(16'(r) * 16'h0841) ^ 16'h5A00;
        do_cmd(mk(1, 1, 0, 5'(r), PHY_AT, w), res);
        exp_w = mk(0, 1, 1, 5'(r), PHY_AT, w);
        chk(res == exp_w, "R7 write completion word", res, exp_w);
        chk(phy_regs[r] == w, "R4 write frame decoded by PHY", {16'h0, phy_regs[r]}, {16'h0, w});
        do_cmd(mk(1, 0, 0, 5'(r), PHY_AT, 16'h0), res);
        exp_w = mk(0, 0, 1, 5'(r), PHY_AT, w);
        chk(res == exp_w, "R6 read-back after write", res, exp_w);
      end
    end

    // R4: write to another address does not reach this PHY
    w = phy_regs[4];
    do_cmd(mk(1, 1, 0, 5'd4, PHY_NONE, 16'h0F0F), res);
    chk(phy_regs[4] == w, "R4 address field honoured", {16'h0, phy_regs[4]}, {16'h0, w});

    chk(max_lat <= 2 * FRAME_CYC + 16, "R9 host command latency", 32'(max_lat),
        32'(2 * FRAME_CYC + 16));

    // R8: maps after full scan rounds
    repeat (32 * (FRAME_CYC + POLL_GAP + 16) + 200) @(negedge clk);
    chk(alive == (32'h1 << PHY_AT), "R8 alive map", alive, 32'h1 << PHY_AT);
    chk(link == (32'h1 << PHY_AT), "R8 link map up", link, 32'h1 << PHY_AT);
    phy_regs[1] = phy_regs[1] & ~16'h0004;
    repeat (32 * (FRAME_CYC + POLL_GAP + 16) + 200) @(negedge clk);
    chk(link == 32'h0, "R8 link map down", link, 32'h0);
    chk(alive == (32'h1 << PHY_AT), "R8 alive kept with link down", alive, 32'h1 << PHY_AT);

    summary();
    $finish;
  end
endmodule